// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two phase signals and the index signal of an incremental shaft encoder into a 16-bit position count. A 3-bit mode field selects one of four things: no operation, a free-running timer, x2 decoding or x4 decoding. In each decoding mode the counter resets in one of two ways. Either an index pulse clears it, or it wraps between zero and a programmable maximum count.

Software reaches the block through a small register port. Writes are synchronous and reads are combinational. Three registers are mapped: control/status, maximum count and position count. The phase and index inputs are synchronised inside the block. A phase-swap control corrects wiring that was reversed. A direction pin output, with its own enable, shows which way the counter last moved. A sticky count-error flag catches index pulses that arrive at the wrong place.

Register map: address 0 is control/status, address 1 is the maximum count, address 2 is the position count, and address 3 reads as zero. Control/status bits:

| Bits | Meaning |
|------|---------|
| [2:0] | mode |
| [3] | phase swap |
| [4] | direction pin enable |
| [5] | direction |
| [6] | index level, read-only |
| [7] | count error |

Top module: `quad_pos_counter`

## Requirements
- R1: After reset, every control field, the maximum count and the position count are 0. The block does not count, and `dirPinOe` is 0.
- R2: Mode values 000, 010 and 011 leave the position count unchanged whatever the phase inputs do.
- R3: Modes 111 and 110 (x4) change the count by one on every single-phase edge. The count goes up for the phase sequence (A,B) = 00, 10, 11, 01 and down for the reverse sequence.
- R4: Modes 101 and 100 (x2) count only on edges of phase A. The count goes up when A differs from B after the edge and down otherwise. Edges of phase B alone leave the count unchanged.
- R5: In encoder modes, a sample in which both phases change together leaves the count unchanged.
- R6: In modes 111, 101 and 001, a step up from the maximum count gives 0, and a step down from 0 gives the maximum count.
- R7: In modes 110 and 100, a rising edge of the index input clears the count to 0. In other modes the index input does not change the count.
- R8: In modes 110 and 100, an index rising edge sets control bit 7 when the count is neither 0 nor the maximum count. Writing 0 to bit 7 clears it. The bit is never set in any other mode.
- R9: When control bit 3 is 1, the two phases are exchanged before decoding, so the sequence from R3 counts down.
- R10: Control bit 5 reads 1 after an upward step and 0 after a downward step. Writes to it are ignored while the mode is 1xx.
- R11: In mode 001, the count steps once per clock, up when bit 5 is 1 and down when it is 0. Bit 5 can be written whenever the mode is not 1xx.
- R12: Control bit 6 reads the synchronised level of the index input.
- R13: When control bit 4 is 1, `dirPinOe` is 1 and `dirPinOut` equals bit 5. When bit 4 is 0, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address |
| wrData | input | 16 | Write data |
| rdAddr | input | 2 | Read address |
| rdData | output | 16 | Read data, combinational |
| phaseA | input | 1 | Encoder phase A |
| phaseB | input | 1 | Encoder phase B |
| indexIn | input | 1 | Encoder index |
| dirPinOut | output | 1 | Direction pin value |
| dirPinOe | output | 1 | Direction pin drive enable |

## Verification
The assertions assume the phase inputs move along the Gray sequence at most one step per synchroniser delay. They also assume software changes the swap setting only while the block is not decoding, so that a swap never shows up as a phantom step. The stimulus follows these rules. It holds each phase level for four clocks, changes the swap and the mode only while the mode is 000, and breaks the Gray rule only in the one deliberate double-change case. The assertions on wrap and clear results also assume that a position write in the same cycle has priority. The bench never collides a write with a step.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

  typedef enum logic [2:0] {
    MODE_OFF      = 3'b000,
    MODE_TIMER    = 3'b001,
    MODE_NONE2    = 3'b010,
    MODE_NONE3    = 3'b011,
    MODE_X2_INDEX = 3'b100,
    MODE_X2_MATCH = 3'b101,
    MODE_X4_INDEX = 3'b110,
    MODE_X4_MATCH = 3'b111
  } qpcMode_e;

  typedef struct packed {
    logic stepUp;
    logic stepDown;
    logic wrapEn;
    logic clearCnt;
    logic loadCnt;
  } qpcStrobe_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_MAX  = 2'd1;
  localparam logic [1:0] ADDR_POS  = 2'd2;

endpackage

// File: rtl/qpc_ctrl.sv
module qpc_ctrl
  import qpc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          phaseA,
  input  logic          phaseB,
  input  logic          indexIn,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [6:0]    ctrlWr,   // {err, dir, pinEn, swap, mode[2:0]}
  input  logic          atZero,
  input  logic          atMax,
  output qpcStrobe_t    strb,
  output logic [7:0]    ctrlWord,
  output logic          dirState,
  output logic          pinEn
);

  logic [SYNC_STAGES-1:0] syncA, syncB, syncI;
  qpcMode_e mode;
  logic swap, errFlag;
  logic prevA, prevB, prevI;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      syncA <= '0;
      syncB <= '0;
      syncI <= '0;
    end else begin
      syncA <= {syncA[SYNC_STAGES-2:0], phaseA};
      syncB <= {syncB[SYNC_STAGES-2:0], phaseB};
      syncI <= {syncI[SYNC_STAGES-2:0], indexIn};
    end
  end

  logic aNow, bNow, idxNow;
  assign aNow   = swap ? syncB[SYNC_STAGES-1] : syncA[SYNC_STAGES-1];
  assign bNow   = swap ? syncA[SYNC_STAGES-1] : syncB[SYNC_STAGES-1];
  assign idxNow = syncI[SYNC_STAGES-1];

  logic aChg, bChg, idxRise;
  logic encMode, x4Mode, idxMode, matchMode, timerMode;
  logic encStep, encUp, errSet, ctrlWrite;

  assign aChg      = aNow ^ prevA;
  assign bChg      = bNow ^ prevB;
  assign idxRise   = idxNow & ~prevI;
  assign encMode   = mode[2];
  assign x4Mode    = mode[1];
  assign idxMode   = mode[2] & ~mode[0];
  assign matchMode = mode[2] & mode[0];
  assign timerMode = (mode == MODE_TIMER);
  assign encStep   = encMode & (x4Mode ? (aChg ^ bChg) : (aChg & ~bChg));
  assign encUp     = aNow ^ prevB;
  assign errSet    = idxMode & idxRise & ~atZero & ~atMax;
  assign ctrlWrite = wrEn && (wrAddr == ADDR_CTRL);

  always_comb begin
    strb.stepUp   = (encStep & encUp) | (timerMode & dirState);
    strb.stepDown = (encStep & ~encUp) | (timerMode & ~dirState);
    strb.wrapEn   = matchMode | timerMode;
    strb.clearCnt = idxMode & idxRise;
    strb.loadCnt  = wrEn && (wrAddr == ADDR_POS);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prevA    <= 1'b0;
      prevB    <= 1'b0;
      prevI    <= 1'b0;
      mode     <= MODE_OFF;
      swap     <= 1'b0;
      pinEn    <= 1'b0;
      dirState <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      prevA <= aNow;
      prevB <= bNow;
      prevI <= idxNow;
      if (ctrlWrite) begin
        mode  <= qpcMode_e'(ctrlWr[2:0]);
        swap  <= ctrlWr[3];
        pinEn <= ctrlWr[4];
      end
      if (encStep)
        dirState <= encUp;
      else if (ctrlWrite && !encMode)
        dirState <= ctrlWr[5];
      if (errSet)
        errFlag <= 1'b1;
      else if (ctrlWrite && !ctrlWr[6])
        errFlag <= 1'b0;
    end
  end

  assign ctrlWord = {errFlag, idxNow, dirState, pinEn, swap, mode};

  // R5: only one direction strobe at a time; simultaneous phase change never steps
  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.stepUp, strb.stepDown}));
  a_r5_no_double_step: assert property (@(posedge clk) disable iff (!rst_n)
    (encMode && aChg && bChg) |-> !(strb.stepUp || strb.stepDown));
  // R8: error flag rises only out of an index-reset mode
  a_r8_err_index_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(errFlag) |-> $past(idxMode));
  // R10: direction bit cannot change in encoder modes without a step
  a_r10_dir_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (encMode && !encStep) |=> $stable(dirState));

endmodule

// File: rtl/qpc_datapath.sv
module qpc_datapath
  import qpc_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  qpcStrobe_t    strb,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] posCount,
  output logic [DW-1:0] maxCount,
  output logic          atZero,
  output logic          atMax
);

  assign atZero = (posCount == '0);
  assign atMax  = (posCount == maxCount);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      posCount <= '0;
      maxCount <= '0;
    end else begin
      if (wrEn && wrAddr == ADDR_MAX)
        maxCount <= wrData;
      if (strb.loadCnt)
        posCount <= wrData;
      else if (strb.clearCnt)
        posCount <= '0;
      else if (strb.stepUp)
        posCount <= (strb.wrapEn && atMax) ? '0 : posCount + DW'(1);
      else if (strb.stepDown)
        posCount <= (strb.wrapEn && atZero) ? maxCount : posCount - DW'(1);
    end
  end

  // R3: plain step up adds one
  a_r3_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.stepUp && !strb.loadCnt && !strb.clearCnt && !(strb.wrapEn && atMax))
    |=> posCount == $past(posCount) + DW'(1));
  // R6: wrap at the top and bottom
  a_r6_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.stepUp && strb.wrapEn && atMax && !strb.loadCnt && !strb.clearCnt)
    |=> posCount == '0);
  a_r6_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.stepDown && strb.wrapEn && atZero && !strb.loadCnt && !strb.clearCnt)
    |=> posCount == $past(maxCount));
  // R7: index clear
  a_r7_index_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.clearCnt && !strb.loadCnt) |=> posCount == '0);

endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter
  import qpc_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic [AW-1:0] rdAddr,
  output logic [DW-1:0] rdData,
  input  logic          phaseA,
  input  logic          phaseB,
  input  logic          indexIn,
  output logic          dirPinOut,
  output logic          dirPinOe
);

  qpcStrobe_t strb;
  logic [7:0] ctrlWord;
  logic [DW-1:0] posCount, maxCount;
  logic atZero, atMax, dirState, pinEn;

  qpc_ctrl #(.SYNC_STAGES(2), .AW(AW)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .phaseA(phaseA), .phaseB(phaseB), .indexIn(indexIn),
    .wrEn(wrEn), .wrAddr(wrAddr), .ctrlWr({wrData[7], wrData[5:0]}),
    .atZero(atZero), .atMax(atMax),
    .strb(strb), .ctrlWord(ctrlWord), .dirState(dirState), .pinEn(pinEn)
  );

  qpc_datapath #(.DW(DW), .AW(AW)) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .posCount(posCount), .maxCount(maxCount),
    .atZero(atZero), .atMax(atMax)
  );

  always_comb begin
    case (rdAddr)
      ADDR_CTRL: rdData = {{(DW-8){1'b0}}, ctrlWord};
      ADDR_MAX:  rdData = maxCount;
      ADDR_POS:  rdData = posCount;
      default:   rdData = '0;
    endcase
  end

  assign dirPinOe  = pinEn;
  assign dirPinOut = pinEn & dirState;

  // R13: pin follows the direction bit only while enabled
  a_r13_pin: assert property (@(posedge clk) disable iff (!rst_n)
    !dirPinOe |-> !dirPinOut);

endmodule

// File: tb/quad_pos_counter_tb_top.sv
`timescale 1ns/1ps
module quad_pos_counter_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = '0, rdAddr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic phaseA = 1'b0, phaseB = 1'b0, indexIn = 1'b0;
  logic dirPinOut, dirPinOe;

  int nRun = 0, nFail = 0;
  int pos = 0;
  int expCnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  quad_pos_counter dut_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .phaseA(phaseA), .phaseB(phaseB),
    .indexIn(indexIn), .dirPinOut(dirPinOut), .dirPinOe(dirPinOe)
  );

  task automatic chk(input string req, input int act, input int exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    rdAddr = a; #0.5;
    v = int'(rdData);
  endtask

  function automatic logic gA(input int p); return (p == 1 || p == 2); endfunction
  function automatic logic gB(input int p); return (p == 2 || p == 3); endfunction

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic step(input int d);
    pos = (pos + d + 4) % 4;
    phaseA = gA(pos); phaseB = gB(pos);
    settle();
  endtask

  task automatic pulseIndex();
    indexIn = 1'b1; settle();
    indexIn = 1'b0; settle();
  endtask

  initial begin
    #400000;
    nRun++; nFail++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    int v, v2, mx;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(0, v); chk("R1 ctrl", v, 0);
    rd(2, v); chk("R1 pos", v, 0);
    rd(1, v); chk("R1 max", v, 0);
    chk("R1 pinOe", int'(dirPinOe), 0);
    for (int i = 0; i < 4; i++) step(1);
    rd(2, v); chk("R1 off no count", v, 0);

    // R2: disabled codes
    wr(0, 16'h0002);
    for (int i = 0; i < 4; i++) step(1);
    rd(2, v); chk("R2 mode 010", v, 0);
    wr(0, 16'h0003);
    for (int i = 0; i < 4; i++) step(-1);
    rd(2, v); chk("R2 mode 011", v, 0);

    // R3/R6: x4 match sweep, max 5
    wr(0, 16'h0000); wr(1, 16'd5); wr(2, 16'd0); wr(0, 16'h0007);
    expCnt = 0;
    for (int i = 0; i < 14; i++) begin
      step(1);
      expCnt = (expCnt == 5) ? 0 : expCnt + 1;
      rd(2, v); chk("R3/R6 x4 up", v, expCnt);
    end
    rd(0, v); chk("R10 dir up", (v >> 5) & 1, 1);
    for (int i = 0; i < 14; i++) begin
      step(-1);
      expCnt = (expCnt == 0) ? 5 : expCnt - 1;
      rd(2, v); chk("R3/R6 x4 down", v, expCnt);
    end
    rd(0, v); chk("R10 dir down", (v >> 5) & 1, 0);
    wr(0, 16'h0027);
    rd(0, v); chk("R10 dir write ignored", (v >> 5) & 1, 0);

    // R5: both phases change in one sample
    wr(2, 16'd3); expCnt = 3;
    pos = (pos + 2) % 4; phaseA = gA(pos); phaseB = gB(pos); settle();
    rd(2, v); chk("R5 double change", v, 3);
    // R7: index ignored in match mode, no error
    pulseIndex();
    rd(2, v); chk("R7 match ignores index", v, 3);
    rd(0, v); chk("R8 no err in match", (v >> 7) & 1, 0);

    // R4: x2 match, max 7
    wr(0, 16'h0000); wr(1, 16'd7); wr(2, 16'd0); wr(0, 16'h0005);
    expCnt = 0;
    for (int i = 0; i < 8; i++) begin
      logic aOld;
      aOld = gA(pos);
      step(1);
      if (aOld != gA(pos)) expCnt = (expCnt == 7) ? 0 : expCnt + 1;
      rd(2, v); chk("R4 x2 up", v, expCnt);
    end
    for (int i = 0; i < 12; i++) begin
      logic aOld;
      aOld = gA(pos);
      step(-1);
      if (aOld != gA(pos)) expCnt = (expCnt == 0) ? 7 : expCnt - 1;
      rd(2, v); chk("R4 x2 down", v, expCnt);
    end

    // R7/R8: x4 index mode
    wr(0, 16'h0000); wr(1, 16'd100); wr(0, 16'h0006); wr(2, 16'd3);
    pulseIndex();
    rd(2, v); chk("R7 index clear", v, 0);
    rd(0, v); chk("R8 err set", (v >> 7) & 1, 1);
    wr(0, 16'h0006);
    rd(0, v); chk("R8 err clear", (v >> 7) & 1, 0);
    pulseIndex();
    rd(0, v); chk("R8 no err at zero", (v >> 7) & 1, 0);
    wr(2, 16'd100);
    pulseIndex();
    rd(2, v); chk("R7 clear from max", v, 0);
    rd(0, v); chk("R8 no err at max", (v >> 7) & 1, 0);
    // x2 index mode also flags
    wr(0, 16'h0004); wr(2, 16'd9);
    pulseIndex();
    rd(0, v); chk("R8 err x2 index", (v >> 7) & 1, 1);

    // R9: swap
    wr(0, 16'h0000); pos = 0; phaseA = 0; phaseB = 0; settle();
    wr(0, 16'h000E); wr(2, 16'd10);
    for (int i = 0; i < 3; i++) step(1);
    rd(2, v); chk("R9 swap reverses", v, 7);

    // R12/R13
    wr(0, 16'h0000);
    indexIn = 1'b1; settle();
    rd(0, v); chk("R12 index high", (v >> 6) & 1, 1);
    indexIn = 1'b0; settle();
    rd(0, v); chk("R12 index low", (v >> 6) & 1, 0);
    wr(0, 16'h0030);
    chk("R13 oe", int'(dirPinOe), 1);
    chk("R13 pin", int'(dirPinOut), 1);
    wr(0, 16'h0020);
    chk("R13 released", int'(dirPinOe) + int'(dirPinOut), 0);

    // R11: timer
    wr(1, 16'hFFFF); wr(2, 16'd100); wr(0, 16'h0021);
    rd(2, v); repeat (10) @(posedge clk); @(negedge clk); rd(2, v2);
    chk("R11 timer up", (v2 - v + 65536) % 65536, 10);
    wr(0, 16'h0000); wr(0, 16'h0001);
    rd(2, v); repeat (10) @(posedge clk); @(negedge clk); rd(2, v2);
    chk("R11 timer down", (v - v2 + 65536) % 65536, 10);
    wr(0, 16'h0000); wr(1, 16'd3); wr(2, 16'd0); wr(0, 16'h0021);
    rd(2, v);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); rd(2, v2);
      chk("R6 timer wrap", v2, (v + 1) % 4);
      v = v2;
    end
    rd(1, mx); chk("R6 max readback", mx, 3);
    rd(3, v); chk("R1 unmapped", v, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule